// File: doc/BRIEF.md
# Blink Plane Selector and Segment Decoder

This block forms the segment byte for whichever digit the display scanner is driving. Every digit has two stored bytes, one in plane 0 and one in plane 1. A blink timer, advanced by oscillator clock enables, divides time into a first half and a second half. With blinking enabled, the block shows plane 0 during the first half and plane 1 during the second half. A segment can therefore be dark, lit, lit only in the first half, or lit only in the second half, depending on its two stored bits.

The plane choice is held in a register. That register only updates on a digit-slot boundary, so the choice never changes part way through a slot. A sync pulse clears the timer and returns the phase to the first half, which lets several drivers blink in step. After the plane is chosen, a per-digit mask decides how the byte is shown. A digit with its mask bit set is decoded as a hexadecimal glyph, with the decimal point taken straight from bit 7. A digit with its mask bit clear drives its segments directly from the stored byte.

The segment output is a combinational function of the current inputs and the registered plane choice. There is no stream handshake: the scanner presents a digit and reads back its pattern in the same cycle.

Top module: `blink_seg_decoder`

## Requirements
- R1: After reset the blink counter is zero, the timer is in the first half, and the plane choice selects plane 0.
- R2: When `blink_en` is low on a cycle with `slot_start` high, plane 0 is selected from the next cycle onward.
- R3: Each blink half lasts SLOW_HALF counted ticks when `fast_rate` is 0, and SLOW_HALF/2 counted ticks when `fast_rate` is 1. With `blink_en` high, the half the timer is in when a `slot_start` cycle occurs is the plane used from the next cycle: plane 0 for the first half, plane 1 for the second.
- R4: The timer counts only on cycles where `osc_tick` is 1 and `shutdown` is 0. While `shutdown` is high, both the count and the half stay frozen.
- R5: A `sync` cycle clears the counter, puts the timer in the first half and selects plane 0 from the next cycle. `sync` takes priority over ticks and slot boundaries.
- R6: The plane choice changes only at the clock edge that ends a cycle in which `slot_start` or `sync` is high.
- R7: Bit i of `dec_mask` selects decoding for digit i. When that bit is 0, `seg_out` equals the selected byte unchanged. The output bit order is bit 7 dp, bit 6 a, bit 5 b, bit 4 c, bit 3 d, bit 2 e, bit 1 f, bit 0 g.
- R8: For a decoded digit, bit 7 of the selected byte drives dp directly, bits 3:0 pick the glyph, and bits 6:4 have no effect.
- R9: The decoded glyphs (a..g in bits 6:0) for values 0 to F are 7E, 30, 6D, 79, 33, 5B, 5F, 70, 7F, 7B, 77, 1F, 4E, 3D, 4F, 47.
- R10: A cleared (all-zero) byte shows 0x7E on a decoded digit and 0x00 on an undecoded digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | Oscillator clock enable that advances the blink timer |
| shutdown | input | 1 | Freezes the blink timer while high |
| sync | input | 1 | Clears the timer and restarts the first half |
| blink_en | input | 1 | Enables alternation between the two planes |
| fast_rate | input | 1 | 1 selects the fast (half-length) blink |
| slot_start | input | 1 | Marks a digit-slot boundary; the plane choice updates here |
| digit_idx | input | DIGIT_W | Index of the digit being scanned |
| dec_mask | input | NUM_DIGITS | Per-digit hexadecimal decode enable |
| plane0_byte | input | 8 | Plane 0 byte of the scanned digit |
| plane1_byte | input | 8 | Plane 1 byte of the scanned digit |
| seg_out | output | 8 | Segment pattern, dp then a..g |

## Verification
`seg_out` responds in the same cycle as the byte, mask and index inputs. It responds one rising edge after a `slot_start` or `sync` cycle for a change of plane. The blink half flips on the edge that ends the last counted tick of a half. The bench changes its inputs on the falling edge and compares 1 ns later. It checks against a reference model of counter, half and plane choice, and that model advances on every rising edge using the inputs that were stable across that edge. Directed runs use a short half length. This lets the bench cross half boundaries, shutdown freezes and sync resets at known cycle counts.

// File: rtl/blink_seg_decoder_pkg.sv
package blink_seg_decoder_pkg;

  typedef logic [7:0] seg_byte_t;

  // glyph bits 6:0 = a,b,c,d,e,f,g
  function automatic logic [6:0] hex_glyph(input logic [3:0] nib);
    logic [6:0] g;
    case (nib)
      4'h0: g = 7'h7E;
      4'h1: g = 7'h30;
      4'h2: g = 7'h6D;
      4'h3: g = 7'h79;
      4'h4: g = 7'h33;
      4'h5: g = 7'h5B;
      4'h6: g = 7'h5F;
      4'h7: g = 7'h70;
      4'h8: g = 7'h7F;
      4'h9: g = 7'h7B;
      4'hA: g = 7'h77;
      4'hB: g = 7'h1F;
      4'hC: g = 7'h4E;
      4'hD: g = 7'h3D;
      4'hE: g = 7'h4F;
      default: g = 7'h47;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/blink_phase_timer.sv
module blink_phase_timer #(
  parameter int SLOW_HALF = 4_000_000,
  parameter int CNT_W     = $clog2(SLOW_HALF)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_tick,
  input  logic             shutdown,
  input  logic             sync,
  input  logic             fast_rate,
  output logic [CNT_W-1:0] half_cnt,
  output logic             blink_half
);
  localparam int FAST_HALF = (SLOW_HALF / 2 < 1) ? 1 : SLOW_HALF / 2;
  localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_HALF - 1);
  localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_HALF - 1);

  logic [CNT_W-1:0] last_cnt;
  logic             advance;

  assign last_cnt = fast_rate ? FAST_LAST : SLOW_LAST;
  assign advance  = osc_tick && !shutdown;

  always_ff @(posedge clk) begin
    if (!rst_n || sync) begin
      half_cnt   <= '0;
      blink_half <= 1'b0;
    end else if (advance) begin
      if (half_cnt >= last_cnt) begin
        half_cnt   <= '0;
        blink_half <= ~blink_half;
      end else begin
        half_cnt <= half_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/plane_select_reg.sv
module plane_select_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic sync,
  input  logic slot_start,
  input  logic blink_en,
  input  logic blink_half,
  output logic plane_sel
);
  always_ff @(posedge clk) begin
    if (!rst_n || sync) begin
      plane_sel <= 1'b0;
    end else if (slot_start) begin
      plane_sel <= blink_en && blink_half;
    end
  end
endmodule

// File: rtl/seg_decoder.sv
module seg_decoder
  import blink_seg_decoder_pkg::*;
#(
  parameter int NUM_DIGITS = 8,
  parameter int DIGIT_W    = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
  input  logic [DIGIT_W-1:0]    digit_idx,
  input  logic [NUM_DIGITS-1:0] dec_mask,
  input  seg_byte_t             shown_byte,
  output seg_byte_t             seg_out
);
  logic decode_on;

  assign decode_on = dec_mask[digit_idx];

  always_comb begin
    if (decode_on) begin
      seg_out = {shown_byte[7], hex_glyph(shown_byte[3:0])};
    end else begin
      seg_out = shown_byte;
    end
  end
endmodule

// File: rtl/blink_seg_decoder.sv
module blink_seg_decoder
  import blink_seg_decoder_pkg::*;
#(
  parameter int NUM_DIGITS = 8,
  parameter int SLOW_HALF  = 4_000_000,
  parameter int DIGIT_W    = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1,
  parameter int CNT_W      = $clog2(SLOW_HALF)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  osc_tick,
  input  logic                  shutdown,
  input  logic                  sync,
  input  logic                  blink_en,
  input  logic                  fast_rate,
  input  logic                  slot_start,
  input  logic [DIGIT_W-1:0]    digit_idx,
  input  logic [NUM_DIGITS-1:0] dec_mask,
  input  logic [7:0]            plane0_byte,
  input  logic [7:0]            plane1_byte,
  output logic [7:0]            seg_out
);
  logic [CNT_W-1:0] half_cnt;
  logic             blink_half;
  logic             plane_sel;
  seg_byte_t        shown_byte;

  blink_phase_timer #(.SLOW_HALF(SLOW_HALF), .CNT_W(CNT_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .shutdown(shutdown),
    .sync(sync), .fast_rate(fast_rate), .half_cnt(half_cnt),
    .blink_half(blink_half)
  );

  plane_select_reg sel_i (
    .clk(clk), .rst_n(rst_n), .sync(sync), .slot_start(slot_start),
    .blink_en(blink_en), .blink_half(blink_half), .plane_sel(plane_sel)
  );

  assign shown_byte = plane_sel ? plane1_byte : plane0_byte;

  seg_decoder #(.NUM_DIGITS(NUM_DIGITS), .DIGIT_W(DIGIT_W)) dec_i (
    .digit_idx(digit_idx), .dec_mask(dec_mask), .shown_byte(shown_byte),
    .seg_out(seg_out)
  );
endmodule

// File: rtl/blink_seg_decoder_chk.sv
module blink_seg_decoder_chk #(
  parameter int NUM_DIGITS = 8,
  parameter int DIGIT_W    = 3,
  parameter int CNT_W      = 22
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  shutdown,
  input logic                  sync,
  input logic                  blink_en,
  input logic                  slot_start,
  input logic [DIGIT_W-1:0]    digit_idx,
  input logic [NUM_DIGITS-1:0] dec_mask,
  input logic [7:0]            plane0_byte,
  input logic [7:0]            plane1_byte,
  input logic [7:0]            seg_out,
  input logic [CNT_W-1:0]      half_cnt,
  input logic                  blink_half,
  input logic                  plane_sel
);
  logic [7:0] chosen;
  assign chosen = plane_sel ? plane1_byte : plane0_byte;

  AST_BLINK_OFF_P0: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_start && !blink_en) |=> !plane_sel); // R2
  AST_FROZEN_IN_SHUTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown && !sync) |=> ($stable(half_cnt) && $stable(blink_half))); // R4
  AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> (half_cnt == '0 && !blink_half && !plane_sel)); // R5
  AST_SEL_SLOT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_start && !sync) |=> $stable(plane_sel)); // R6
  AST_RAW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_mask[digit_idx] |-> seg_out == chosen); // R7
  AST_DP_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    seg_out[7] == chosen[7]); // R8
endmodule

bind blink_seg_decoder blink_seg_decoder_chk #(
  .NUM_DIGITS(NUM_DIGITS), .DIGIT_W(DIGIT_W), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .shutdown(shutdown), .sync(sync),
  .blink_en(blink_en), .slot_start(slot_start), .digit_idx(digit_idx),
  .dec_mask(dec_mask), .plane0_byte(plane0_byte), .plane1_byte(plane1_byte),
  .seg_out(seg_out), .half_cnt(half_cnt), .blink_half(blink_half),
  .plane_sel(plane_sel)
);

// File: tb/blink_seg_decoder_tb_top.sv
module blink_seg_decoder_tb_top;
  localparam int ND = 8;
  localparam int DW = 3;
  localparam int SH = 8;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_tick = 1'b0, shutdown = 1'b0, sync = 1'b0;
  logic blink_en = 1'b0, fast_rate = 1'b0, slot_start = 1'b0;
  logic [DW-1:0] digit_idx = '0;
  logic [ND-1:0] dec_mask = '0;
  logic [7:0] plane0_byte = '0, plane1_byte = '0;
  logic [7:0] seg_out;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  // reference model state
  int  m_cnt = 0;
  bit  m_half = 0;
  bit  m_sel = 0;

  always #5 clk = ~clk;

  blink_seg_decoder #(.NUM_DIGITS(ND), .SLOW_HALF(SH), .DIGIT_W(DW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .shutdown(shutdown),
    .sync(sync), .blink_en(blink_en), .fast_rate(fast_rate),
    .slot_start(slot_start), .digit_idx(digit_idx), .dec_mask(dec_mask),
    .plane0_byte(plane0_byte), .plane1_byte(plane1_byte), .seg_out(seg_out)
  );

  function automatic logic [6:0] ref_glyph(input logic [3:0] v);
    logic [6:0] t;
    case (v)
      0: t = 7'h7E;  1: t = 7'h30;  2: t = 7'h6D;  3: t = 7'h79;
      4: t = 7'h33;  5: t = 7'h5B;  6: t = 7'h5F;  7: t = 7'h70;
      8: t = 7'h7F;  9: t = 7'h7B;  10: t = 7'h77; 11: t = 7'h1F;
      12: t = 7'h4E; 13: t = 7'h3D; 14: t = 7'h4F; default: t = 7'h47;
    endcase
    return t;
  endfunction

  function automatic logic [7:0] ref_seg();
    logic [7:0] b;
    b = m_sel ? plane1_byte : plane0_byte;
    if (dec_mask[digit_idx]) return {b[7], ref_glyph(b[3:0])};
    return b;
  endfunction

  task automatic check(input string tag, input logic [7:0] exp);
    n_checks++;
    if (seg_out !== exp) begin
      n_errors++;
      $display("FAIL %s: seg_out=%02h expected=%02h at %0t", tag, seg_out, exp, $time);
    end
  endtask

  // one cycle: inputs already driven; compare, then advance model across the edge
  task automatic step(input string tag);
    int lim;
    #1 check(tag, ref_seg());
    @(posedge clk);
    if (!rst_n || sync) begin
      m_cnt = 0; m_half = 0; m_sel = 0;
    end else begin
      if (slot_start) m_sel = blink_en && m_half;
      if (osc_tick && !shutdown) begin
        lim = fast_rate ? SH / 2 : SH;
        if (m_cnt >= lim - 1) begin m_cnt = 0; m_half = !m_half; end
        else m_cnt++;
      end
    end
    @(negedge clk);
  endtask

  initial begin
    int wd = 0;
    while (!done) begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        n_errors++;
        $display("FAIL watchdog: cycles=%0d expected<=150000", wd);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    step("R1");
    step("R1");
    rst_n = 1'b1;
    // R1: reset state shows plane 0 undecoded
    plane0_byte = 8'hA5; plane1_byte = 8'h5A; slot_start = 1'b1;
    blink_en = 1'b1;
    step("R1");
    // R9 / R8: every glyph, with junk in bits 6:4
    dec_mask = '1; slot_start = 1'b0; blink_en = 1'b0;
    for (int v = 0; v < 16; v++) begin
      plane0_byte = {v[0], 3'($urandom), 4'(v)};
      digit_idx = 3'($urandom);
      step("R9");
      check("R8", {plane0_byte[7], ref_glyph(4'(v))});
    end
    // R10: cleared bytes
    plane0_byte = 8'h00; plane1_byte = 8'h00; dec_mask = 8'b0000_0101;
    digit_idx = 3'd2; step("R10"); check("R10", 8'h7E);
    digit_idx = 3'd1; step("R10"); check("R10", 8'h00);
    // R3: slow blink, tick every cycle, slot every cycle
    dec_mask = '0; plane0_byte = 8'h0F; plane1_byte = 8'hF0;
    sync = 1'b1; step("R5"); sync = 1'b0;
    blink_en = 1'b1; osc_tick = 1'b1; slot_start = 1'b1; fast_rate = 1'b0;
    for (int c = 0; c < 4 * SH; c++) step("R3");
    fast_rate = 1'b1;
    for (int c = 0; c < 4 * SH; c++) step("R3");
    // R4: freeze while shut down
    shutdown = 1'b1;
    for (int c = 0; c < 3 * SH; c++) step("R4");
    shutdown = 1'b0;
    // R2: disable blink
    blink_en = 1'b0;
    for (int c = 0; c < 2 * SH; c++) begin step("R2"); check("R2", 8'h0F); end
    // R6: slot boundary holds the plane
    blink_en = 1'b1; slot_start = 1'b0;
    for (int c = 0; c < 3 * SH; c++) begin step("R6"); check("R6", 8'h0F); end
    // R5: sync mid-blink
    slot_start = 1'b1;
    for (int c = 0; c < SH + 2; c++) step("R3");
    sync = 1'b1; step("R5"); sync = 1'b0; step("R5"); check("R5", 8'h0F);
    // random mix
    for (int c = 0; c < 6000; c++) begin
      osc_tick    = ($urandom % 4) != 0;
      shutdown    = ($urandom % 8) == 0;
      sync        = ($urandom % 64) == 0;
      slot_start  = ($urandom % 4) == 0;
      if (($urandom % 32) == 0) blink_en = ~blink_en;
      if (($urandom % 64) == 0) fast_rate = ~fast_rate;
      if (($urandom % 16) == 0) dec_mask = 8'($urandom);
      digit_idx   = 3'($urandom);
      plane0_byte = 8'($urandom);
      plane1_byte = 8'($urandom);
      if (dec_mask[digit_idx]) step("R8"); else step("R7");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule